// File: doc/BRIEF.md
# Proximity Card Activation Controller

This block is the card-side controller that takes a Type A proximity card from power-up to selection. It receives frames that have already been demodulated and delivered whole. Each frame comes with its data bytes, a short-frame flag, a valid-bit count and a CRC-ok flag. A field-present input says whether a reader field is powering the card. From these the block moves the card through its activation states. For each command it accepts, it asks the transmitter for a reply frame and says what that reply holds: the request answer, the UID followed by its check byte, or the select acknowledge.

The card has one fixed 4-byte UID, so one cascade level (select code 0x93) is all it needs. The halted state is distinct: it answers only the wakeup command. Anticollision and select share a select code, and the block tells them apart by the NVB byte. A halted card that is woken remembers that it was woken. If a later frame is malformed or unexpected, the card drops back to halted rather than idle.

Top module: `card_activator`

## Requirements
- R1: The `state` output is encoded as 0 powered-off, 1 idle, 2 ready, 3 active, 4 halted, 5 protocol. A low `field_on` puts the block in powered-off at the next clock edge. A high `field_on` in powered-off moves it to idle at the next edge.
- R2: In idle, a short frame with valid-bit count 7 and code 0x26 (request) or 0x52 (wakeup) in `rx_data[6:0]` gives a reply of kind 1 and moves the block to ready. The reply carries the answer word with byte 0 in `tx_data[7:0]`.
- R3: A frame whose short flag is clear, or whose valid-bit count is not 7, is never decoded as request or wakeup. In idle such a frame gives no reply and leaves the state unchanged.
- R4: In halted, only the wakeup code moves the block to ready with a kind 1 reply. The request code and every other frame are ignored, with no reply and no state change.
- R5: In ready, a standard frame of 16 bits with byte 0 = 0x93 and byte 1 = 0x20 gives a kind 2 reply. The reply holds the UID bytes in `tx_data[31:0]`, first byte lowest, and the check byte in `tx_data[39:32]`. The block stays in ready.
- R6: The check byte is the XOR of the four UID bytes. For UID EA 24 77 15 it is AC.
- R7: In ready, a 56-bit standard frame with bytes 0x93, 0x70, the four UID bytes and the check byte, received with `rx_crc_ok` high, gives a kind 3 reply carrying the acknowledge byte in `tx_data[7:0]`. The block moves to active.
- R8: A select frame with any wrong UID bit, a wrong check byte or a failed CRC gives no reply and is treated as unexpected (R10).
- R9: In active, a 16-bit standard frame 0x50 0x00 with a good CRC moves the block to halted with no reply.
- R10: Any other frame in ready or active gives no reply. It returns the block to halted if the block was last woken from halted, and to idle otherwise.
- R11: In active, a 16-bit standard frame with byte 0 = 0xE0 and a good CRC moves the block to protocol with no reply. In protocol every frame is ignored until the field drops.
- R12: A reply is signalled by a one-cycle `tx_valid` at the clock edge that takes in the `rx_valid` frame. It is produced only for a frame received while the field is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| field_on | input | 1 | Reader field present |
| rx_valid | input | 1 | One-cycle strobe: a complete frame is on the rx inputs |
| rx_short | input | 1 | Frame was a short frame |
| rx_bits | input | 6 | Valid data bits in the frame, excluding CRC |
| rx_data | input | 56 | Frame bytes, byte 0 in bits 7:0 |
| rx_crc_ok | input | 1 | Frame CRC checked good |
| state | output | 3 | Activation state (encoding in R1) |
| tx_valid | output | 1 | One-cycle reply request |
| tx_kind | output | 2 | Reply kind: 1 answer word, 2 UID and check byte, 3 acknowledge |
| tx_data | output | 40 | Reply bytes, byte 0 in bits 7:0, unused bits zero |

## Verification
The bench sweeps all 128 seven-bit codes in idle and again in halted. A decoder that lets the request code wake a halted card, or that matches on fewer bits, answers a code it should ignore. It also sweeps the valid-bit count and flips each UID bit in turn inside a select frame. A design that skips the bit-count check, or compares the UID only in part, would reach active on a frame it should reject. The return path after a bad frame is checked from both idle-origin and halted-origin selections, so a design that forgets the wakeup origin lands in the wrong state. Replies are also checked for exact byte order and for silence after halt and after the protocol command.

// File: rtl/card_activator.sv
module card_activator #(
  parameter logic [31:0] CARD_UID = 32'h1577_24EA,
  parameter logic [15:0] ATQA_VAL = 16'h0004,
  parameter logic [7:0]  SAK_VAL  = 8'h08
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        field_on,
  input  logic        rx_valid,
  input  logic        rx_short,
  input  logic [5:0]  rx_bits,
  input  logic [55:0] rx_data,
  input  logic        rx_crc_ok,
  output logic [2:0]  state,
  output logic        tx_valid,
  output logic [1:0]  tx_kind,
  output logic [39:0] tx_data
);
  localparam logic [2:0] S_OFF = 3'd0, S_IDLE = 3'd1, S_READY = 3'd2,
                         S_ACT = 3'd3, S_HALT = 3'd4, S_PROT = 3'd5;
  localparam logic [1:0] K_NONE = 2'd0, K_ATQA = 2'd1, K_UID = 2'd2, K_SAK = 2'd3;
  localparam logic [7:0] CHK = CARD_UID[7:0] ^ CARD_UID[15:8] ^ CARD_UID[23:16] ^ CARD_UID[31:24];

  logic woke;
  logic [2:0] nxt;
  logic nxt_woke;
  logic [1:0] kind;

  wire [7:0] b0 = rx_data[7:0];
  wire [7:0] b1 = rx_data[15:8];
  wire short7 = rx_short && rx_bits == 6'd7;
  wire is_req = short7 && rx_data[6:0] == 7'h26;
  wire is_wup = short7 && rx_data[6:0] == 7'h52;
  wire std16 = !rx_short && rx_bits == 6'd16;
  wire is_acl = std16 && b0 == 8'h93 && b1 == 8'h20;
  wire is_sel = !rx_short && rx_bits == 6'd56 && b0 == 8'h93 && b1 == 8'h70 &&
                rx_data[47:16] == CARD_UID && rx_data[55:48] == CHK && rx_crc_ok;
  wire is_hlt = std16 && b0 == 8'h50 && b1 == 8'h00 && rx_crc_ok;
  wire is_rats = std16 && b0 == 8'hE0 && rx_crc_ok;
  wire [2:0] fall_back = woke ? S_HALT : S_IDLE;

  always_comb begin
    nxt = state;
    nxt_woke = woke;
    kind = K_NONE;
    if (rx_valid) begin
      case (state)
        S_IDLE: if (is_req || is_wup) begin
          nxt = S_READY; nxt_woke = 1'b0; kind = K_ATQA;
        end
        S_HALT: if (is_wup) begin
          nxt = S_READY; nxt_woke = 1'b1; kind = K_ATQA;
        end
        S_READY: if (is_acl) kind = K_UID;
                 else if (is_sel) begin nxt = S_ACT; kind = K_SAK; end
                 else nxt = fall_back;
        S_ACT: if (is_hlt) nxt = S_HALT;
               else if (is_rats) nxt = S_PROT;
               else nxt = fall_back;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_OFF;
      woke <= 1'b0;
      tx_valid <= 1'b0;
      tx_kind <= K_NONE;
      tx_data <= '0;
    end else if (!field_on) begin
      state <= S_OFF;
      woke <= 1'b0;
      tx_valid <= 1'b0;
      tx_kind <= K_NONE;
    end else if (state == S_OFF) begin
      state <= S_IDLE;
      tx_valid <= 1'b0;
    end else begin
      state <= nxt;
      woke <= nxt_woke;
      tx_valid <= kind != K_NONE;
      tx_kind <= kind;
      case (kind)
        K_ATQA: tx_data <= {24'h0, ATQA_VAL};
        K_UID:  tx_data <= {CHK, CARD_UID};
        K_SAK:  tx_data <= {32'h0, SAK_VAL};
        default: ;
      endcase
    end
  end
endmodule

module card_activator_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        field_on,
  input logic        rx_valid,
  input logic        rx_short,
  input logic [5:0]  rx_bits,
  input logic [55:0] rx_data,
  input logic [2:0]  state,
  input logic        tx_valid,
  input logic [1:0]  tx_kind
);
  wire wup_in = rx_valid && rx_short && rx_bits == 6'd7 && rx_data[6:0] == 7'h52;

  // R1
  field_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !field_on |=> state == 3'd0);
  // R4
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd4 && field_on && !wup_in) |=> state == 3'd4);
  // R12
  tx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(rx_valid && field_on));
  // R7
  sak_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_kind == 2'd3) |-> (state == 3'd3 && $past(state) == 3'd2));
  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd4 && $past(state) == 3'd3) |-> !tx_valid);
  // R11
  proto_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd5 && field_on) |=> state == 3'd5);
endmodule

bind card_activator card_activator_chk u_chk (
  .clk(clk), .rst_n(rst_n), .field_on(field_on), .rx_valid(rx_valid),
  .rx_short(rx_short), .rx_bits(rx_bits), .rx_data(rx_data),
  .state(state), .tx_valid(tx_valid), .tx_kind(tx_kind)
);

// File: tb/card_activator_tb.sv
module card_activator_tb;
  logic clk = 0, rst_n = 0, field_on = 0, rx_valid = 0, rx_short = 0, rx_crc_ok = 0;
  logic [5:0] rx_bits = 0;
  logic [55:0] rx_data = 0;
  logic [2:0] state;
  logic tx_valid;
  logic [1:0] tx_kind;
  logic [39:0] tx_data;
  int errs = 0, nchk = 0;

  localparam logic [31:0] UID = 32'h1577_24EA;
  localparam logic [7:0] BCC = UID[7:0] ^ UID[15:8] ^ UID[23:16] ^ UID[31:24];
  localparam logic [55:0] SEL = {BCC, UID, 8'h70, 8'h93};

  card_activator u_dut (.*);

  always #10 clk = ~clk;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(logic s, logic [5:0] b, logic [55:0] d, logic c);
    @(negedge clk);
    rx_valid = 1; rx_short = s; rx_bits = b; rx_data = d; rx_crc_ok = c;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic to_idle;
    @(negedge clk); field_on = 0;
    @(negedge clk); check("R1 off", state, 0);
    field_on = 1;
    @(negedge clk); check("R1 idle", state, 1);
  endtask

  task automatic to_ready(logic from_halt);
    if (from_halt) begin
      to_halt();
      send(1, 7, 56'h52, 0);
    end else begin
      to_idle();
      send(1, 7, 56'h26, 0);
    end
    check("R2 ready", state, 2);
  endtask

  task automatic to_active(logic from_halt);
    to_ready(from_halt);
    send(0, 56, SEL, 1);
    check("R7 active", state, 3);
  endtask

  task automatic to_halt;
    to_active(0);
    send(0, 16, 56'h0050, 1);
    check("R9 halt", state, 4);
    check("R9 silent", tx_valid, 0);
  endtask

  initial begin
    #1_000_000;
    errs++; nchk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset state", state, 0);
    check("R12 reset tx", tx_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 stays off", state, 0);

    for (int c = 0; c < 128; c++) begin
      logic hit;
      hit = (c == 'h26) || (c == 'h52);
      to_idle();
      send(1, 7, 56'(c), 0);
      check("R2 idle sweep tx", tx_valid, hit);
      check("R2 idle sweep state", state, hit ? 2 : 1);
      if (hit) begin
        check("R12 atqa kind", tx_kind, 1);
        check("R2 atqa data", tx_data, 40'h0004);
      end
    end

    for (int b = 0; b < 57; b++) begin
      if (b != 7) begin
        to_idle();
        send(1, 6'(b), 56'h26, 1);
        check("R3 bits sweep", {state, tx_valid}, {3'd1, 1'b0});
      end
    end
    to_idle();
    send(0, 7, 56'h52, 1);
    check("R3 non-short", {state, tx_valid}, {3'd1, 1'b0});

    for (int c = 0; c < 128; c++) begin
      logic hit;
      hit = (c == 'h52);
      to_halt();
      send(1, 7, 56'(c), 0);
      check("R4 halt sweep tx", tx_valid, hit);
      check("R4 halt sweep state", state, hit ? 2 : 4);
    end
    to_halt();
    send(0, 16, 56'h2093, 1);
    check("R4 halt ignores anticollision", {state, tx_valid}, {3'd4, 1'b0});

    to_ready(0);
    for (int k = 0; k < 2; k++) begin
      send(0, 16, 56'h2093, 0);
      check("R5 anticol tx", tx_valid, 1);
      check("R5 anticol kind", tx_kind, 2);
      check("R6 uid+check", tx_data, {8'hAC, 32'h1577_24EA});
      check("R5 stays ready", state, 2);
    end
    send(0, 56, SEL, 1);
    check("R7 sak tx", tx_valid, 1);
    check("R7 sak kind", tx_kind, 3);
    check("R7 sak data", tx_data, 40'h08);
    check("R7 state", state, 3);

    for (int i = 0; i < 40; i++) begin
      to_ready(i[0]);
      send(0, 56, SEL ^ (56'd1 << (16 + i)), 1);
      check("R8 corrupt tx", tx_valid, 0);
      check("R10 corrupt return", state, i[0] ? 4 : 1);
    end
    to_ready(0);
    send(0, 56, SEL, 0);
    check("R8 crc fail", {state, tx_valid}, {3'd1, 1'b0});
    to_ready(1);
    send(0, 48, SEL, 1);
    check("R10 short select", {state, tx_valid}, {3'd4, 1'b0});

    to_active(0);
    send(1, 7, 56'h26, 0);
    check("R10 active unexpected idle", {state, tx_valid}, {3'd1, 1'b0});
    to_active(1);
    send(0, 16, 56'h0050, 0);
    check("R10 active bad crc halt", {state, tx_valid}, {3'd4, 1'b0});
    to_active(1);
    send(0, 16, 56'h0050, 1);
    check("R9 halt again", {state, tx_valid}, {3'd4, 1'b0});

    to_active(0);
    send(0, 16, 56'h50E0, 1);
    check("R11 protocol", {state, tx_valid}, {3'd5, 1'b0});
    send(1, 7, 56'h52, 0);
    check("R11 ignores wakeup", {state, tx_valid}, {3'd5, 1'b0});
    send(0, 16, 56'h0050, 1);
    check("R11 ignores halt", {state, tx_valid}, {3'd5, 1'b0});
    @(negedge clk); field_on = 0;
    @(negedge clk);
    check("R1 drop from protocol", state, 0);

    to_ready(0);
    @(negedge clk);
    field_on = 0; rx_valid = 1; rx_short = 0; rx_bits = 16; rx_data = 56'h2093;
    @(negedge clk);
    rx_valid = 0;
    check("R12 no reply without field", {state, tx_valid}, {3'd0, 1'b0});

    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule